// File: doc/BRIEF.md
# Quadrature Encoder Counter with Selectable Edges

This block turns two asynchronous encoder lines, `in_a` and `in_b`, into a 16-bit position count. Each line goes through its own two-flop synchronizer and an edge detector. A decode stage then picks out the edges that the edge selector allows. In simple mode it counts only `in_a` edges, and each one steps the count up. In quadrature mode it steps up or down on edges of either line. The direction comes from which line moved, which way it moved, and the level of the other line.

The count runs cyclically over the closed range 0..`preset`. Stepping up from the preset returns to 0, and stepping down from 0 goes to the preset. If `preset` is lowered below the current count, the count clears to 0. When both lines change in the same clock in quadrature mode, the event cannot be resolved. The count then holds and a sticky error flag is raised. A direction output shows which way the last counted step went.

Top module: `qenc_counter`

## Requirements
- R1: The count is 16 bits wide, always lies in 0..`preset` once settled, and moves by exactly one per counted edge.
- R2: A counted up-step from `count == preset` gives 0, and a counted down-step from 0 gives `preset`.
- R3: In simple mode (`quad_mode = 0`), each selected edge of `in_a` steps the count up, and `in_b` has no effect on the count.
- R4: `edge_sel` encoding: 2'b00 counts rising edges only, 2'b01 falling edges only, and 2'b10 or 2'b11 both edges.
- R5: Quadrature mode, rising edges. `in_a` rising steps down when `in_b` is high and up when it is low. `in_b` rising steps up when `in_a` is high and down when it is low. Falling edges are not counted under 2'b00.
- R6: Quadrature mode, falling edges. `in_a` falling steps up when `in_b` is high and down when it is low. `in_b` falling steps down when `in_a` is high and up when it is low. Rising edges are not counted under 2'b01.
- R7: With both edges selected in quadrature mode, every edge of either line is counted, and its direction follows R5 for rising edges and R6 for falling edges.
- R8: If `preset` is below `count`, the count becomes 0 on the next clock. This takes priority over any step and over `enable`.
- R9: While `enable` is low, the count, direction and error flag hold. Edges seen while disabled are not counted later.
- R10: In quadrature mode with `enable` high, a change of both synchronized lines in the same clock leaves the count unchanged and sets `err_flag`. The flag stays set until reset.
- R11: `dir_up` shows the direction of the most recent counted step (1 = up).
- R12: After reset, `count` is 0, `dir_up` is 1 and `err_flag` is 0. A single input change is counted at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Encoder line A, asynchronous |
| in_b | input | 1 | Encoder line B, asynchronous |
| quad_mode | input | 1 | 1 = quadrature, 0 = simple count on line A |
| edge_sel | input | 2 | Counted edges: 00 rising, 01 falling, 1x both |
| enable | input | 1 | Counting enable |
| preset | input | 16 | Upper end of the count range |
| count | output | 16 | Current count |
| dir_up | output | 1 | Direction of the last counted step |
| err_flag | output | 1 | Sticky flag for simultaneous line changes |

## Verification
Three functions can land in the same clock edge: a wrap at either end of the range, a preset shrink, and a decoded step. The bench walks the encoder forward and backward through full Gray cycles with a small preset, so that wraps happen on up-steps and on down-steps. It lowers the preset below the count to check that the clear wins. It also changes both lines in one clock to provoke the collision path. The count, `dir_up` and `err_flag` are compared against values the bench computes from the R5 and R6 direction rules and the wrap arithmetic.

// File: rtl/qenc_pkg.sv
// Shared types for the quadrature encoder counter.
// Assumes: edge selection is a 2-bit field; code 2'b11 behaves as both edges.
package qenc_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10
    } edge_sel_e;
endpackage

// File: rtl/qenc_sync.sv
// Synchronizes one asynchronous line into the clock domain and flags its edges.
// Assumes: the line is held low while reset is applied, so no false edge follows reset.
module qenc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], din};
    end

    // Keep the last synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign level = chain[LAST];
    assign rise  = chain[LAST] & ~prev;
    assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/qenc_step_decode.sv
// Turns synchronized edges into a step request with a direction.
// Assumes: each line shows at most one edge per clock; lvl holds the post-edge levels.
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic       quad_mode,
    input  logic [1:0] edge_sel,
    input  logic [1:0] lvl,    // [0] = line A, [1] = line B
    input  logic [1:0] rise,
    input  logic [1:0] fall,
    output logic       step,
    output logic       step_up,
    output logic       clash
);
    logic use_rise, use_fall;
    logic a_r, a_f, b_r, b_f;

    assign use_rise = (edge_sel != EDGE_FALL);
    assign use_fall = (edge_sel != EDGE_RISE);
    assign a_r = rise[0] & use_rise;
    assign a_f = fall[0] & use_fall;
    assign b_r = rise[1] & use_rise;
    assign b_f = fall[1] & use_fall;

    // Decide whether a step happens and which way it goes.
    always_comb begin
        step    = 1'b0;
        step_up = 1'b1;
        clash   = 1'b0;
        if (!quad_mode) begin
            step = a_r | a_f;
        end else if ((rise[0] | fall[0]) && (rise[1] | fall[1])) begin
            clash = 1'b1;
        end else if (a_r) begin
            step    = 1'b1;
            step_up = ~lvl[1];
        end else if (a_f) begin
            step    = 1'b1;
            step_up = lvl[1];
        end else if (b_r) begin
            step    = 1'b1;
            step_up = lvl[0];
        end else if (b_f) begin
            step    = 1'b1;
            step_up = ~lvl[0];
        end
    end
endmodule

// File: rtl/qenc_count_core.sv
// Cyclic up/down counter over 0..preset with direction and sticky error state.
// Assumes: preset may change at any clock; a shrink below the count clears it.
module qenc_count_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [WIDTH-1:0] preset,
    input  logic             step,
    input  logic             step_up,
    input  logic             clash,
    output logic [WIDTH-1:0] count,
    output logic             dir_up,
    output logic             err_flag
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] next_up, next_dn;

    assign next_up = (count >= preset) ? ZERO : count + ONE;
    assign next_dn = (count == ZERO) ? preset : count - ONE;

    // Advance, wrap or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= ZERO;
        else if (preset < count)      count <= ZERO;
        else if (enable && step)      count <= step_up ? next_up : next_dn;
    end

    // Remember the direction of the last counted step.
    always_ff @(posedge clk) begin
        if (!rst_n)              dir_up <= 1'b1;
        else if (enable && step) dir_up <= step_up;
    end

    // Latch a simultaneous-change event until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               err_flag <= 1'b0;
        else if (enable && clash) err_flag <= 1'b1;
    end
endmodule

// File: rtl/qenc_counter.sv
// Top level: two synchronized encoder lines feed a step decoder and a cyclic counter.
// Assumes: encoder lines are low during reset and change slower than three clocks.
module qenc_counter #(
    parameter int WIDTH     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             quad_mode,
    input  logic [1:0]       edge_sel,
    input  logic             enable,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             dir_up,
    output logic             err_flag
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, lvl, rise, fall;
    logic             step, step_up, clash;

    assign raw = {in_b, in_a};

    for (genvar ch = 0; ch < LINES; ch++) begin : g_line
        qenc_sync #(.STAGES(SYNC_DEPTH)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[ch]),
            .level (lvl[ch]),
            .rise  (rise[ch]),
            .fall  (fall[ch])
        );
    end

    qenc_step_decode u_dec (
        .quad_mode (quad_mode),
        .edge_sel  (edge_sel),
        .lvl       (lvl),
        .rise      (rise),
        .fall      (fall),
        .step      (step),
        .step_up   (step_up),
        .clash     (clash)
    );

    qenc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .preset   (preset),
        .step     (step),
        .step_up  (step_up),
        .clash    (clash),
        .count    (count),
        .dir_up   (dir_up),
        .err_flag (err_flag)
    );
endmodule

// File: rtl/qenc_counter_chk.sv
// Property checker for the quadrature encoder counter, bound to the top module.
// Assumes: it observes only the top-level ports.
module qenc_counter_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             quad_mode,
    input logic             enable,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             dir_up,
    input logic             err_flag
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    AST_SHRINK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (count > preset) |=> (count == '0)); // R8

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count < preset && count != '0) |=>
        (count == $past(count) || count == $past(count) + ONE || count == $past(count) - ONE)); // R1

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && count <= preset) |=> ($stable(count) && $stable(dir_up))); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R10

    AST_SIMPLE_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!quad_mode && count < preset) |=> (count >= $past(count))); // R3

    AST_SIMPLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!quad_mode && !err_flag) |=> !err_flag); // R10
endmodule

bind qenc_counter qenc_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .quad_mode (quad_mode),
    .enable    (enable),
    .preset    (preset),
    .count     (count),
    .dir_up    (dir_up),
    .err_flag  (err_flag)
);

// File: tb/qenc_counter_tb_top.sv
// Self-checking bench: sweeps encoder walks over every edge setting and mode.
module qenc_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_a = 1'b0, in_b = 1'b0;
    logic        quad_mode = 1'b1;
    logic [1:0]  edge_sel = 2'b00;
    logic        enable = 1'b1;
    logic [15:0] preset = 16'd5;
    logic [15:0] count;
    logic        dir_up, err_flag;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    bit exp_dir = 1'b1;
    bit exp_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_counter dut_i (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
        .quad_mode(quad_mode), .edge_sel(edge_sel), .enable(enable),
        .preset(preset), .count(count), .dir_up(dir_up), .err_flag(err_flag)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0; exp_dir = 1'b1; exp_err = 1'b0;
    endtask

    // Expected step from the direction rules: +1, -1 or 0.
    function automatic int model_step(bit q, logic [1:0] es, bit a, bit b, bit na, bit nb);
        bit ur = (es != 2'b01);
        bit uf = (es != 2'b00);
        bit ra = !a && na, fa = a && !na, rb = !b && nb, fb = b && !nb;
        if (!q) return ((ra && ur) || (fa && uf)) ? 1 : 0;
        if ((a != na) && (b != nb)) return 0;
        if (ra && ur) return nb ? -1 : 1;
        if (fa && uf) return nb ? 1 : -1;
        if (rb && ur) return na ? 1 : -1;
        if (fb && uf) return na ? -1 : 1;
        return 0;
    endfunction

    // Drive new line levels, wait past the three-edge latency, compare.
    task automatic move(string req, bit na, bit nb);
        int d;
        d = model_step(quad_mode, edge_sel, in_a, in_b, na, nb);
        if (enable) begin
            if (quad_mode && (in_a != na) && (in_b != nb)) exp_err = 1'b1;
            if (d == 1)  begin exp_cnt = (exp_cnt == int'(preset)) ? 0 : exp_cnt + 1; exp_dir = 1'b1; end
            if (d == -1) begin exp_cnt = (exp_cnt == 0) ? int'(preset) : exp_cnt - 1; exp_dir = 1'b0; end
        end
        @(negedge clk);
        in_a = na; in_b = nb;
        repeat (4) @(negedge clk);
        chk({req, " count"}, int'(count), exp_cnt);
        chk({req, " dir"}, int'(dir_up), int'(exp_dir));
        chk({req, " err"}, int'(err_flag), int'(exp_err));
    endtask

    task automatic gray_walk(string req, bit fwd, int cycles);
        for (int c = 0; c < cycles; c++) begin
            if (fwd) begin
                move(req, 1, 0); move(req, 1, 1); move(req, 0, 1); move(req, 0, 0);
            end else begin
                move(req, 0, 1); move(req, 1, 1); move(req, 1, 0); move(req, 0, 0);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R12: reset state
        chk("R12 count", int'(count), 0);
        chk("R12 dir", int'(dir_up), 1);
        chk("R12 err", int'(err_flag), 0);

        // R12 latency: no change after two edges, change after the third
        @(negedge clk); in_a = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 latency early", int'(count), 0);
        @(negedge clk);
        chk("R12 latency", int'(count), 1);
        exp_cnt = 1;
        move("R12", 0, 0);

        // R4 R5 R6 R7 R2: quadrature sweep over each edge setting, both directions
        for (int es = 0; es < 4; es++) begin
            do_reset();
            quad_mode = 1'b1; edge_sel = 2'(es); preset = 16'd5;
            gray_walk("R5 R6 R7 R2 R4 fwd", 1'b1, 4);
            gray_walk("R5 R6 R7 R2 R4 rev", 1'b0, 5);
        end

        // R3 R4: simple mode, line B toggling ignored, wrap at preset
        for (int es = 0; es < 3; es++) begin
            do_reset();
            quad_mode = 1'b0; edge_sel = 2'(es); preset = 16'd3;
            for (int k = 0; k < 5; k++) begin
                move("R3 R2", 1, 0); move("R3 b ignored", 1, 1);
                move("R3 R2", 0, 1); move("R3 b ignored", 0, 0);
            end
        end

        // R8: shrink preset below count clears count
        do_reset();
        quad_mode = 1'b1; edge_sel = 2'b10; preset = 16'd20;
        gray_walk("R8 setup", 1'b1, 2);
        chk("R8 before", int'(count), 8);
        @(negedge clk); preset = 16'd3; enable = 1'b0;
        @(negedge clk);
        chk("R8 cleared", int'(count), 0);
        exp_cnt = 0;
        enable = 1'b1;
        move("R8 count after", 1, 0);

        // R9: edges while disabled are not counted
        @(negedge clk); enable = 1'b0;
        move("R9 hold", 1, 1); move("R9 hold", 0, 1);
        @(negedge clk); enable = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 after re-enable", int'(count), exp_cnt);
        move("R9 resumes", 0, 0);

        // R10 R11: simultaneous change holds count, sets sticky error
        move("R11 down", 0, 1);
        chk("R11 dir down", int'(dir_up), 0);
        move("R10 clash", 1, 0);
        chk("R10 err set", int'(err_flag), 1);
        move("R10 sticky", 1, 1);
        chk("R10 still set", int'(err_flag), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule